// File: doc/BRIEF.md
# DRAM Refresh Postponement Scheduler

This block paces all-bank auto-refresh commands for a DRAM controller. A free-running interval timer expires once per refresh period (tREFI, a parameter in clock cycles). At each expiry the block either asks for a refresh at once or, when postponing is enabled and the controller still has queued work in some bank, defers it and adds one to a count of deferred refreshes. The deferred refreshes are later issued back to back as a burst, one refresh every tRFC cycles. After the burst the next interval is shortened, so the long-run refresh cadence stays on the tREFI grid.

The controller sees a single request line that stays high until it accepts the command, and a busy line that is high while a burst is running or a refresh is waiting to be accepted. Configuration inputs turn refreshing off, enable postponing, force the block to wait for the full postpone count, and set that count.

Top module: `refresh_postpone_sched`

## Requirements
- R1: While reset is held, `refReq` and `refBusy` are low. The first interval expiry is REFI_CYC cycles after reset is released, so `refReq` is first high in cycle REFI_CYC (cycle 1 being the cycle after the first clock edge with reset released), and never earlier.
- R2: With `cfgPostponeEn` low, every interval expiry yields exactly one refresh, whatever `bankPending` shows, and expiries are REFI_CYC cycles apart.
- R3: An expiry outside a burst adds one to the deferred count. While that count is below the limit and some bit of `bankPending` is set, no refresh is requested.
- R4: When the deferred count reaches the limit (`cfgMaxPostpone` with postponing enabled), a burst starts at that expiry and issues as many refreshes as the count holds.
- R5: Without force mode, a burst also starts at an expiry that finds every bit of `bankPending` clear, issuing every deferred refresh including the current one.
- R6: With `cfgPostponeEn` and `cfgForceMax` both set, an idle `bankPending` does not start a burst; bursts start only at the limit.
- R7: Inside a burst, expiries are RFC_CYC cycles apart and each issues one refresh; changes of `bankPending` during a burst have no effect on its length.
- R8: After a burst of n refreshes, the next expiry comes REFI_CYC − (n−1)·RFC_CYC cycles after the burst's last expiry, so the burst after it starts a whole number of REFI_CYC from the first; later expiries return to REFI_CYC spacing.
- R9: `refReq` stays high until a cycle with `refAck` high (or refresh is turned off); the interval timer keeps running while a request waits.
- R10: Two accepted refreshes start at least RFC_CYC cycles apart; a refresh owed earlier waits for that distance.
- R11: While `cfgRefreshOff` is high, `refReq` stays low and all deferred and owed refreshes are discarded; expiries keep their REFI_CYC spacing.
- R12: `refBusy` is high while a burst is running or a refresh is owed, and low otherwise.
- R13: A `cfgMaxPostpone` of 0 with postponing enabled acts as a limit of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| bankPending | input | NUM_BANKS | One bit per bank, set while that bank has queued requests |
| refAck | input | 1 | Controller accepts the refresh in the cycle `refReq` is high |
| cfgRefreshOff | input | 1 | Suppress all refreshes |
| cfgPostponeEn | input | 1 | Allow deferring refreshes |
| cfgForceMax | input | 1 | With postponing on, wait for the full limit |
| cfgMaxPostpone | input | CNT_W | Deferred-refresh limit |
| refReq | output | 1 | Refresh request, held until accepted |
| refBusy | output | 1 | Burst running or refresh owed |

## Verification
The hard cases are the burst edges: a design that counted the triggering expiry after deciding would issue one refresh too few, and one that re-checked the bank flags inside a burst would cut it short when traffic returns. The interval after a multi-refresh burst is checked at the exact cycle, since dropping the shortening, or applying it twice, slides every later burst off the tREFI grid. Delayed acceptance is driven both for a lone request and inside a burst, where a design that restarted the timer on acceptance or ignored the tRFC spacing after a late start would drift or crowd commands. Force mode with idle banks, a zero limit, and a refresh-off window followed by re-enable close the list, and a long random run with changing configuration is checked cycle by cycle against a bench model.

// File: rtl/refpp_pkg.sv
package refpp_pkg;

  // Which length the interval timer reloads with at an expiry.
  typedef enum logic [1:0] {
    IV_REFI  = 2'd0,   // plain refresh period
    IV_RFC   = 2'd1,   // spacing inside a burst
    IV_ALIGN = 2'd2    // shortened period after a burst
  } ivSel_e;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic   reload;    // reload the interval timer
    ivSel_e ivSel;     // reload length
    logic   incCnt;    // add one deferred refresh
    logic   decCnt;    // remove one deferred refresh
    logic   latchLen;  // remember the burst length
    logic   issue;     // owe one refresh to the controller
    logic   clrState;  // refresh turned off: drop everything
  } strobes_t;

endpackage

// File: rtl/refpp_ctrl.sv
module refpp_ctrl
  import refpp_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int CNT_W     = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 expire,
  input  logic [CNT_W-1:0]     cnt,
  input  logic [NUM_BANKS-1:0] bankPending,
  input  logic                 cfgRefreshOff,
  input  logic                 cfgPostponeEn,
  input  logic                 cfgForceMax,
  input  logic [CNT_W-1:0]     cfgMaxPostpone,
  output strobes_t             st,
  output logic                 burst
);

  localparam logic [CNT_W:0] ONE = (CNT_W+1)'(1);

  logic [CNT_W:0] cntPlus;
  logic [CNT_W:0] effMax;
  logic [CNT_W:0] cntAfter;
  logic           anyPending;
  logic           holdFull;
  logic           startNow;
  logic           go;

  always_comb begin
    anyPending = |bankPending;
    holdFull   = cfgPostponeEn & cfgForceMax;
    if (!cfgPostponeEn || cfgMaxPostpone == '0) effMax = ONE;
    else                                        effMax = {1'b0, cfgMaxPostpone};
    // the expiry itself is counted before the burst decision
    cntPlus  = {1'b0, cnt} + (burst ? '0 : ONE);
    startNow = !burst && ((cntPlus >= effMax) || (!anyPending && !holdFull));
    go       = burst || startNow;
    cntAfter = go ? cntPlus - ONE : cntPlus;

    st       = '0;
    st.ivSel = IV_REFI;
    if (cfgRefreshOff) begin
      st.clrState = 1'b1;
      st.reload   = expire;
    end else if (expire) begin
      st.reload   = 1'b1;
      st.incCnt   = !burst;
      st.decCnt   = go;
      st.issue    = go;
      st.latchLen = startNow;
      if (go) st.ivSel = (cntAfter != '0) ? IV_RFC : IV_ALIGN;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)              burst <= 1'b0;
    else if (cfgRefreshOff) burst <= 1'b0;
    else if (expire)        burst <= go && (cntAfter != '0);
  end

endmodule

// File: rtl/refpp_datapath.sv
module refpp_datapath
  import refpp_pkg::*;
#(
  parameter int REFI_CYC = 7800,
  parameter int RFC_CYC  = 350,
  parameter int CNT_W    = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         st,
  input  logic             refAck,
  output logic             expire,
  output logic [CNT_W-1:0] cnt,
  output logic             refReq,
  output logic             owedAny
);

  localparam int TW = $clog2(REFI_CYC + 1);
  localparam int GW = $clog2(RFC_CYC + 1);
  localparam int OW = CNT_W + 1;
  localparam logic [TW-1:0] REFI_M1 = TW'(REFI_CYC - 1);
  localparam logic [TW-1:0] RFC_M1  = TW'(RFC_CYC - 1);
  localparam logic [GW-1:0] GUARD_LD = GW'(RFC_CYC - 1);

  logic [TW-1:0]    timer;
  logic [TW-1:0]    rld;
  logic [GW-1:0]    guard;
  logic [OW-1:0]    owed;
  logic [CNT_W-1:0] burstLen;
  logic [CNT_W-1:0] lenUse;
  logic [31:0]      alignCyc;
  logic             accept;

  assign expire  = (timer == '0);
  assign owedAny = (owed != '0);
  assign refReq  = owedAny && (guard == '0) && !st.clrState;
  assign accept  = refReq && refAck;

  always_comb begin
    lenUse   = st.latchLen ? cnt + CNT_W'(1) : burstLen;
    alignCyc = (32'(lenUse) - 32'd1) * 32'(RFC_CYC);
    case (st.ivSel)
      IV_RFC:   rld = RFC_M1;
      IV_ALIGN: rld = TW'(32'(REFI_CYC) - 32'd1 - alignCyc);
      default:  rld = REFI_M1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timer    <= REFI_M1;
      guard    <= '0;
      owed     <= '0;
      cnt      <= '0;
      burstLen <= '0;
    end else begin
      timer <= st.reload ? rld : timer - TW'(1);

      if (accept)           guard <= GUARD_LD;
      else if (guard != '0) guard <= guard - GW'(1);

      if (st.clrState) begin
        owed <= '0;
        cnt  <= '0;
      end else begin
        owed <= owed + OW'(st.issue) - OW'(accept);
        cnt  <= cnt + CNT_W'(st.incCnt) - CNT_W'(st.decCnt);
      end

      if (st.latchLen) burstLen <= cnt + CNT_W'(1);
    end
  end

endmodule

// File: rtl/refresh_postpone_sched.sv
module refresh_postpone_sched
  import refpp_pkg::*;
#(
  parameter int NUM_BANKS = 8,
  parameter int CNT_W     = 4,
  parameter int REFI_CYC  = 7800,
  parameter int RFC_CYC   = 350
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_BANKS-1:0] bankPending,
  input  logic                 refAck,
  input  logic                 cfgRefreshOff,
  input  logic                 cfgPostponeEn,
  input  logic                 cfgForceMax,
  input  logic [CNT_W-1:0]     cfgMaxPostpone,
  output logic                 refReq,
  output logic                 refBusy
);

  strobes_t         st;
  logic             expire;
  logic [CNT_W-1:0] cnt;
  logic             burst;
  logic             owedAny;

  refpp_ctrl #(
    .NUM_BANKS(NUM_BANKS),
    .CNT_W    (CNT_W)
  ) u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .expire        (expire),
    .cnt           (cnt),
    .bankPending   (bankPending),
    .cfgRefreshOff (cfgRefreshOff),
    .cfgPostponeEn (cfgPostponeEn),
    .cfgForceMax   (cfgForceMax),
    .cfgMaxPostpone(cfgMaxPostpone),
    .st            (st),
    .burst         (burst)
  );

  refpp_datapath #(
    .REFI_CYC(REFI_CYC),
    .RFC_CYC (RFC_CYC),
    .CNT_W   (CNT_W)
  ) u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .st     (st),
    .refAck (refAck),
    .expire (expire),
    .cnt    (cnt),
    .refReq (refReq),
    .owedAny(owedAny)
  );

  assign refBusy = burst | owedAny;

endmodule

// File: rtl/refpp_checker.sv
module refpp_checker #(
  parameter int REFI_CYC = 7800,
  parameter int RFC_CYC  = 350
) (
  input logic clk,
  input logic rstN,
  input logic cfgRefreshOff,
  input logic refAck,
  input logic refReq,
  input logic refBusy
);

  int unsigned sinceRst;
  int unsigned sinceAcc;
  logic        seenAcc;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sinceRst <= 0;
      sinceAcc <= 0;
      seenAcc  <= 1'b0;
    end else begin
      if (sinceRst < 32'h7fff_ffff) sinceRst <= sinceRst + 1;
      if (refReq && refAck) begin
        sinceAcc <= 1;
        seenAcc  <= 1'b1;
      end else if (sinceAcc < 32'h7fff_ffff) begin
        sinceAcc <= sinceAcc + 1;
      end
    end
  end

  // R1: no request before one full interval after reset
  p_first_after_refi_r1: assert property (@(posedge clk) disable iff (!rstN)
    refReq |-> sinceRst >= 32'(REFI_CYC));

  // R9: an unaccepted request stays up
  p_hold_until_ack_r9: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && !refAck && !cfgRefreshOff) |=> (refReq || cfgRefreshOff));

  // R10: tRFC between accepted refresh starts
  p_rfc_spacing_r10: assert property (@(posedge clk) disable iff (!rstN)
    (refReq && seenAcc) |-> sinceAcc >= 32'(RFC_CYC));

  // R11: refresh off silences the request
  p_off_silent_r11: assert property (@(posedge clk) disable iff (!rstN)
    cfgRefreshOff |-> !refReq);

  // R12: busy covers any waiting request
  p_busy_covers_req_r12: assert property (@(posedge clk) disable iff (!rstN)
    refReq |-> refBusy);

endmodule

bind refresh_postpone_sched refpp_checker #(
  .REFI_CYC(REFI_CYC),
  .RFC_CYC (RFC_CYC)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .cfgRefreshOff(cfgRefreshOff),
  .refAck       (refAck),
  .refReq       (refReq),
  .refBusy      (refBusy)
);

// File: tb/tb_refresh_postpone_sched.sv
module tb_refresh_postpone_sched;

  localparam int REFI = 200;
  localparam int RFC  = 12;
  localparam int NB   = 4;
  localparam int CW   = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NB-1:0] bankPending = '0;
  logic          refAck = 1'b1;
  logic          cfgRefreshOff = 1'b0;
  logic          cfgPostponeEn = 1'b0;
  logic          cfgForceMax = 1'b0;
  logic [CW-1:0] cfgMaxPostpone = '0;
  logic          refReq;
  logic          refBusy;

  always #4 clk = ~clk;

  refresh_postpone_sched #(
    .NUM_BANKS(NB), .CNT_W(CW), .REFI_CYC(REFI), .RFC_CYC(RFC)
  ) dut (
    .clk(clk), .rstN(rstN), .bankPending(bankPending), .refAck(refAck),
    .cfgRefreshOff(cfgRefreshOff), .cfgPostponeEn(cfgPostponeEn),
    .cfgForceMax(cfgForceMax), .cfgMaxPostpone(cfgMaxPostpone),
    .refReq(refReq), .refBusy(refBusy)
  );

  int    checks = 0;
  int    fails = 0;
  bit    done = 1'b0;
  string curTag = "R1";

  // bench model state
  int cyc, due, mPost, mLen, mOwed, mLast, accN;
  bit mBurst;
  int accT [64];
  int lim, n;
  bit mReqPre, start;

  task automatic chk(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  function automatic bit expReq();
    return (mOwed > 0) && !cfgRefreshOff && (cyc - mLast >= RFC);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      cyc = 0; due = REFI; mPost = 0; mLen = 0; mOwed = 0;
      mLast = -100000; mBurst = 1'b0; accN = 0;
    end else begin
      mReqPre = expReq();
      if (mReqPre && refAck) begin
        mOwed--; mLast = cyc;
        if (accN < 64) accT[accN] = cyc;
        accN++;
      end
      cyc++;
      if (cfgRefreshOff) begin
        mPost = 0; mBurst = 1'b0; mOwed = 0;
        if (cyc == due) due = cyc + REFI;
      end else if (cyc == due) begin
        lim = (!cfgPostponeEn || cfgMaxPostpone == 0) ? 1 : int'(cfgMaxPostpone);
        n = mBurst ? mPost : mPost + 1;
        start = !mBurst && (n >= lim || (bankPending == '0 && !(cfgPostponeEn && cfgForceMax)));
        if (start) mLen = n;
        if (mBurst || start) begin
          mOwed++; n--; mPost = n; mBurst = (n != 0);
          due = cyc + (mBurst ? RFC : REFI - (mLen - 1) * RFC);
        end else begin
          mPost = n; due = cyc + REFI;
        end
      end
    end
  end

  // cycle-by-cycle comparison against the model, away from the edge
  always @(negedge clk) begin
    #1;
    if (rstN && !done) begin
      chk(refReq === expReq(), curTag, "refReq", int'(refReq), int'(expReq()));
      chk(refBusy === (mBurst || mOwed > 0), curTag, "refBusy", int'(refBusy), int'(mBurst || mOwed > 0));
    end
  end

  task automatic doReset(bit off, bit en, bit frc, int mx, logic [NB-1:0] pend);
    @(negedge clk);
    rstN = 1'b0;
    cfgRefreshOff = off; cfgPostponeEn = en; cfgForceMax = frc;
    cfgMaxPostpone = CW'(mx); bankPending = pend; refAck = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    chk(refReq == 1'b0, "R1", "refReq in reset", int'(refReq), 0);
    chk(refBusy == 1'b0, "R1", "refBusy in reset", int'(refBusy), 0);
    @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic waitUntil(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    void'($urandom(32'd5813));

    // postponing off: one refresh per interval, pending ignored
    curTag = "R2";
    doReset(0, 0, 0, 8, '1);
    waitUntil(5 * REFI + 5);
    chk(accN == 5, "R2", "refresh count", accN, 5);
    chk(accT[0] == REFI, "R1", "first refresh cycle", accT[0], REFI);
    chk(accT[4] == 5 * REFI, "R2", "fifth refresh cycle", accT[4], 5 * REFI);

    // busy traffic until the limit, then a full burst and realignment
    curTag = "R4";
    doReset(0, 1, 0, 8, '1);
    waitUntil(8 * REFI - 5);
    chk(accN == 0, "R3", "no refresh while deferring", accN, 0);
    #1;
    chk(refBusy == 1'b0, "R12", "busy before burst", int'(refBusy), 0);
    waitUntil(8 * REFI + RFC + 2);
    #1;
    chk(refBusy == 1'b1, "R12", "busy during burst", int'(refBusy), 1);
    waitUntil(8 * REFI + 8 * RFC);
    bankPending = '0;
    waitUntil(9 * REFI + 5);
    chk(accN == 9, "R4", "burst plus single", accN, 9);
    chk(accT[0] == 8 * REFI, "R4", "burst start", accT[0], 8 * REFI);
    chk(accT[7] - accT[0] == 7 * RFC, "R7", "burst span", accT[7] - accT[0], 7 * RFC);
    chk(accT[8] == 9 * REFI, "R8", "aligned next refresh", accT[8], 9 * REFI);

    // idle banks start an early burst; pending during burst is ignored
    curTag = "R5";
    doReset(0, 1, 0, 8, '1);
    waitUntil(3 * REFI + 10);
    bankPending = '0;
    waitUntil(4 * REFI + 1);
    bankPending = '1;
    waitUntil(5 * REFI + 5);
    chk(accN == 4, "R5", "early burst size", accN, 4);
    chk(accT[0] == 4 * REFI, "R5", "early burst start", accT[0], 4 * REFI);
    chk(accT[3] == 4 * REFI + 3 * RFC, "R7", "last of burst despite pending", accT[3], 4 * REFI + 3 * RFC);
    bankPending = '0;
    waitUntil(7 * REFI + 5);
    chk(accN == 7, "R8", "count after second burst", accN, 7);
    chk(accT[5] == 6 * REFI + RFC, "R7", "two-refresh burst spacing", accT[5], 6 * REFI + RFC);
    chk(accT[6] == 7 * REFI, "R8", "grid after two-refresh burst", accT[6], 7 * REFI);

    // force mode waits for the limit even with idle banks
    curTag = "R6";
    doReset(0, 1, 1, 5, '0);
    waitUntil(5 * REFI - 5);
    chk(accN == 0, "R6", "no early burst in force mode", accN, 0);
    waitUntil(5 * REFI + 5 * RFC);
    chk(accN == 5, "R6", "forced burst size", accN, 5);
    chk(accT[0] == 5 * REFI, "R6", "forced burst start", accT[0], 5 * REFI);

    // late acceptance: held request, tRFC spacing, timer keeps running
    curTag = "R9";
    doReset(0, 1, 0, 2, '1);
    refAck = 1'b0;
    waitUntil(2 * REFI + 5);
    refAck = 1'b1;
    waitUntil(4 * REFI + RFC + 5);
    chk(accT[0] == 2 * REFI + 5, "R9", "held request accepted", accT[0], 2 * REFI + 5);
    chk(accT[1] == 2 * REFI + 5 + RFC, "R10", "owed refresh spacing", accT[1], 2 * REFI + 5 + RFC);
    chk(accT[2] == 4 * REFI, "R9", "timer ran during wait", accT[2], 4 * REFI);
    chk(accN == 4, "R9", "refresh count", accN, 4);

    // refresh off, then back on
    curTag = "R11";
    doReset(1, 0, 0, 8, '0);
    waitUntil(3 * REFI + 5);
    chk(accN == 0, "R11", "no refresh while off", accN, 0);
    cfgRefreshOff = 1'b0;
    waitUntil(4 * REFI + 5);
    chk(accN == 1, "R11", "refresh after re-enable", accN, 1);
    chk(accT[0] == 4 * REFI, "R11", "grid kept while off", accT[0], 4 * REFI);

    // zero limit behaves as one
    curTag = "R13";
    doReset(0, 1, 0, 0, '1);
    waitUntil(3 * REFI + 5);
    chk(accN == 3, "R13", "zero limit refreshes", accN, 3);

    // random traffic and configuration against the model
    curTag = "R3";
    doReset(0, 1, 0, 6, '1);
    for (int i = 0; i < 20000; i++) begin
      @(negedge clk);
      bankPending = NB'($urandom);
      if ($urandom % 3 == 0) bankPending = '0;
      refAck = ($urandom % 4) != 0;
      if (i % 1500 == 1499) begin
        cfgRefreshOff  = ($urandom % 8) == 0;
        cfgPostponeEn  = ($urandom % 4) != 0;
        cfgForceMax    = ($urandom % 3) == 0;
        cfgMaxPostpone = CW'($urandom % 16);
      end
    end
    @(negedge clk);
    finishRun();
  end

endmodule